// File: doc/BRIEF.md
# Column-Parallel Successive-Approximation Conversion Sequencer

This block runs one conversion cycle for a whole row of an image sensor at once. A single shared sequencer steps through a fixed order of phases. It first samples the pixel's reset level and then its signal level, which gives correlated double sampling. It then runs an offset-correction interval, and last it makes a binary search of one trial per result bit, from the most significant bit down. During each trial, every column lane drives its own trial code to its column DAC. It then keeps or clears the bit under test, using its own comparator decision.

The analog side (sampling switches, DAC and comparators) sits outside the block. The block drives the phase strobes and the per-column trial codes, and it takes back one comparator bit per column. When the least significant decision has been made, all column codes are published together and a one-cycle done pulse is raised. When enable is low the converters are idle: every strobe and trial code is held at zero, and any conversion in progress is abandoned.

Top module: `colsar_array_ctrl`

## Requirements
- R1: After reset all strobes, busy_o, done_o, every trial code and every published code are zero.
- R2: A start accepted at a clock edge is followed by exactly SMP_CYC cycles of smp_rst_o, then SMP_CYC cycles of smp_sig_o, then CAL_CYC cycles of cal_o, then BITS cycles of cmp_strobe_o, each phase beginning in the cycle after the previous one ends.
- R3: While cmp_strobe_o is high, a column's trial code holds that column's decided upper bits, a 1 at the bit under test (MSB first), and 0 below it. Outside trials every trial code is zero.
- R4: cmp_i[c] = 1 means the column input is at or above its trial code. The bit under test is kept only then, so the published code equals min(input, 2^BITS-1).
- R5: done_o is high for exactly one cycle, the cycle after the LSB trial, which is 2*SMP_CYC+CAL_CYC+BITS+1 cycles after start is driven. codes_o changes only at that point and holds its value until the next completed conversion.
- R6: A start that arrives while a conversion is in progress is ignored and does not alter the timing of that conversion.
- R7: With enable low, all strobes and trial codes are zero, start is ignored, and a conversion in progress is abandoned without done_o and without changing codes_o.
- R8: At most one of smp_rst_o, smp_sig_o, cal_o, cmp_strobe_o is high in any cycle.
- R9: Each column's code depends only on its own comparator bit.
- R10: busy_o is high from the cycle after an accepted start through the LSB trial cycle, and is low otherwise.
- R11: A start driven in the done cycle is accepted and begins a new conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Converter enable; low means idle |
| start | input | 1 | Conversion request, sampled at the clock edge |
| cmp_i | input | N_COL | Per-column comparator: 1 when the input is at or above the trial code |
| smp_rst_o | output | 1 | Reset-level sample strobe |
| smp_sig_o | output | 1 | Signal-level sample strobe |
| cal_o | output | 1 | Offset-correction strobe |
| cmp_strobe_o | output | 1 | Bit-trial strobe |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle completion pulse |
| trial_o | output | N_COL*BITS | Per-column trial codes; column c is at [c*BITS +: BITS] |
| codes_o | output | N_COL*BITS | Published per-column codes; column c is at [c*BITS +: BITS] |

## Verification
The bench builds the block with 8 columns, 6 bits, 2 sample cycles per level and 3 calibration cycles. A whole conversion then takes 14 cycles, so every phase boundary, the LSB hand-off and the done cycle can each be compared many times. With 6 bits, full-scale inputs, zero inputs, over-range inputs and codes one step either side of the midpoint all fit in a single row. Mid-conversion start pulses, an enable drop during calibration and a start in the done cycle are each run against the cycle-level reference.

// File: rtl/colsar_pkg.sv
package colsar_pkg;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_SRST = 3'd1,
        PH_SSIG = 3'd2,
        PH_CAL  = 3'd3,
        PH_BIT  = 3'd4
    } phase_e;

endpackage

// File: rtl/colsar_seq_ctrl.sv
module colsar_seq_ctrl
    import colsar_pkg::*;
#(
    parameter int BITS    = 10,
    parameter int SMP_CYC = 4,
    parameter int CAL_CYC = 2,
    parameter int BIW     = (BITS > 1) ? $clog2(BITS) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           enable,
    input  logic           start,
    output phase_e         phase_o,
    output logic [BIW-1:0] bit_idx_o,
    output logic           last_o,
    output logic           clr_o,
    output logic           busy_o,
    output logic           done_o
);

    localparam int CNT_MAX = (SMP_CYC > CAL_CYC) ? SMP_CYC : CAL_CYC;
    localparam int CW      = (CNT_MAX > 1) ? $clog2(CNT_MAX) : 1;
    localparam logic [CW-1:0]  SMP_LAST = CW'(SMP_CYC - 1);
    localparam logic [CW-1:0]  CAL_LAST = CW'(CAL_CYC - 1);
    localparam logic [BIW-1:0] MSB_IDX  = BIW'(BITS - 1);

    typedef struct packed {
        phase_e         ph;
        logic [CW-1:0]  cnt;
        logic [BIW-1:0] bidx;
        logic           done;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        clr_o     = 1'b0;
        if (!enable) begin
            st_d.ph  = PH_IDLE;
            st_d.cnt = '0;
        end else begin
            unique case (st_q.ph)
                PH_IDLE: begin
                    if (start) begin
                        st_d.ph  = PH_SRST;
                        st_d.cnt = '0;
                        clr_o    = 1'b1;
                    end
                end
                PH_SRST: begin
                    if (st_q.cnt == SMP_LAST) begin
                        st_d.ph  = PH_SSIG;
                        st_d.cnt = '0;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
                PH_SSIG: begin
                    if (st_q.cnt == SMP_LAST) begin
                        st_d.ph  = PH_CAL;
                        st_d.cnt = '0;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
                PH_CAL: begin
                    if (st_q.cnt == CAL_LAST) begin
                        st_d.ph   = PH_BIT;
                        st_d.cnt  = '0;
                        st_d.bidx = MSB_IDX;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
                PH_BIT: begin
                    if (st_q.bidx == '0) begin
                        st_d.ph   = PH_IDLE;
                        st_d.done = 1'b1;
                    end else begin
                        st_d.bidx = st_q.bidx - 1'b1;
                    end
                end
                default: begin
                    st_d.ph  = PH_IDLE;
                    st_d.cnt = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ph: PH_IDLE, cnt: '0, bidx: '0, done: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_o   = st_q.ph;
    assign bit_idx_o = st_q.bidx;
    assign last_o    = (st_q.bidx == '0);
    assign busy_o    = (st_q.ph != PH_IDLE);
    assign done_o    = st_q.done;

    // done is a single-cycle pulse
    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |=> !st_q.done);

    // signal sampling is entered only from reset sampling
    assert_sig_after_rst_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_SSIG && $past(st_q.ph) != PH_SSIG) |-> $past(st_q.ph) == PH_SRST);

    // bit trials are entered only from calibration
    assert_bit_after_cal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_BIT && $past(st_q.ph) != PH_BIT) |-> $past(st_q.ph) == PH_CAL);

    // a start during signal sampling does not restart the sequence
    assert_busy_start_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_SSIG && enable && start) |=> (st_q.ph == PH_SSIG || st_q.ph == PH_CAL));

    // dropping enable returns to idle with no completion
    assert_disable_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (st_q.ph == PH_IDLE && !st_q.done));

endmodule

// File: rtl/colsar_strobe_gen.sv
module colsar_strobe_gen
    import colsar_pkg::*;
#(
    parameter int BITS = 10,
    parameter int BIW  = (BITS > 1) ? $clog2(BITS) : 1
) (
    input  logic            enable,
    input  phase_e          phase,
    input  logic [BIW-1:0]  bit_idx,
    output logic            smp_rst,
    output logic            smp_sig,
    output logic            cal,
    output logic            cmp_strobe,
    output logic [BITS-1:0] bit_mask
);

    always_comb begin
        smp_rst    = enable && (phase == PH_SRST);
        smp_sig    = enable && (phase == PH_SSIG);
        cal        = enable && (phase == PH_CAL);
        cmp_strobe = enable && (phase == PH_BIT);
    end

    for (genvar i = 0; i < BITS; i++) begin : g_mask
        assign bit_mask[i] = cmp_strobe && (bit_idx == BIW'(i));
    end

endmodule

// File: rtl/colsar_lane.sv
module colsar_lane #(
    parameter int BITS = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            decide,
    input  logic            last,
    input  logic [BITS-1:0] mask,
    input  logic            cmp,
    output logic [BITS-1:0] trial_o,
    output logic [BITS-1:0] code_o
);

    typedef struct packed {
        logic [BITS-1:0] work;
        logic [BITS-1:0] code;
    } lane_t;

    lane_t ln_d, ln_q;

    always_comb begin
        ln_d = ln_q;
        if (clr) begin
            ln_d.work = '0;
        end else if (decide) begin
            ln_d.work = (ln_q.work & ~mask) | (cmp ? mask : '0);
            if (last) begin
                ln_d.code = ln_d.work;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ln_q <= '0;
        end else begin
            ln_q <= ln_d;
        end
    end

    assign trial_o = decide ? (ln_q.work | mask) : '0;
    assign code_o  = ln_q.code;

    // a comparator 1 keeps the bit under test
    assert_bit_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (decide && cmp) |=> ((ln_q.work & $past(mask)) != '0));

    // a comparator 0 clears the bit under test
    assert_bit_dropped_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (decide && !cmp) |=> ((ln_q.work & $past(mask)) == '0));

    // the published code moves only on the last decision
    assert_code_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(decide && last) |=> $stable(ln_q.code));

endmodule

// File: rtl/colsar_array_ctrl.sv
module colsar_array_ctrl
    import colsar_pkg::*;
#(
    parameter int N_COL   = 256,
    parameter int BITS    = 10,
    parameter int SMP_CYC = 4,
    parameter int CAL_CYC = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  enable,
    input  logic                  start,
    input  logic [N_COL-1:0]      cmp_i,
    output logic                  smp_rst_o,
    output logic                  smp_sig_o,
    output logic                  cal_o,
    output logic                  cmp_strobe_o,
    output logic                  busy_o,
    output logic                  done_o,
    output logic [N_COL*BITS-1:0] trial_o,
    output logic [N_COL*BITS-1:0] codes_o
);

    localparam int BIW = (BITS > 1) ? $clog2(BITS) : 1;

    phase_e          phase;
    logic [BIW-1:0]  bit_idx;
    logic            last;
    logic            clr;
    logic [BITS-1:0] bit_mask;

    colsar_seq_ctrl #(
        .BITS    (BITS),
        .SMP_CYC (SMP_CYC),
        .CAL_CYC (CAL_CYC),
        .BIW     (BIW)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .start     (start),
        .phase_o   (phase),
        .bit_idx_o (bit_idx),
        .last_o    (last),
        .clr_o     (clr),
        .busy_o    (busy_o),
        .done_o    (done_o)
    );

    colsar_strobe_gen #(
        .BITS (BITS),
        .BIW  (BIW)
    ) u_strobe (
        .enable     (enable),
        .phase      (phase),
        .bit_idx    (bit_idx),
        .smp_rst    (smp_rst_o),
        .smp_sig    (smp_sig_o),
        .cal        (cal_o),
        .cmp_strobe (cmp_strobe_o),
        .bit_mask   (bit_mask)
    );

    for (genvar c = 0; c < N_COL; c++) begin : g_col
        colsar_lane #(
            .BITS (BITS)
        ) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (clr),
            .decide  (cmp_strobe_o),
            .last    (last),
            .mask    (bit_mask),
            .cmp     (cmp_i[c]),
            .trial_o (trial_o[c*BITS +: BITS]),
            .code_o  (codes_o[c*BITS +: BITS])
        );
    end

    // never two strobes at once
    assert_strobe_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({smp_rst_o, smp_sig_o, cal_o, cmp_strobe_o}));

    // idle converters drive nothing
    assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> ({smp_rst_o, smp_sig_o, cal_o, cmp_strobe_o} == 4'b0 && trial_o == '0));

    // trial codes only during bit trials
    assert_trial_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_strobe_o |-> (trial_o == '0));

    // completion follows a bit trial
    assert_done_after_trial_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(cmp_strobe_o));

endmodule

// File: tb/colsar_array_ctrl_bench.sv
module colsar_array_ctrl_bench;

    localparam int CLK_P = 10;
    localparam int NC    = 8;
    localparam int NB    = 6;
    localparam int SC    = 2;
    localparam int CC    = 3;
    localparam int LAT   = 2*SC + CC + NB + 1;
    localparam int MAXC  = (1 << NB) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0;
    logic start = 1'b0;
    logic [NC-1:0] cmp;
    logic smp_rst, smp_sig, cal, cstb, busy, done;
    logic [NC*NB-1:0] trial, codes;

    int cmp_n = 0;
    int err_n = 0;
    int cyc = 0;
    bit finished = 1'b0;
    int vin [NC];

    // reference model state
    int mph = 0, mcnt = 0, mbit = 0;
    int mwork [NC];
    int mcode [NC];
    bit mdone = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    colsar_array_ctrl #(
        .N_COL   (NC),
        .BITS    (NB),
        .SMP_CYC (SC),
        .CAL_CYC (CC)
    ) u_colsar_array_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (enable),
        .start        (start),
        .cmp_i        (cmp),
        .smp_rst_o    (smp_rst),
        .smp_sig_o    (smp_sig),
        .cal_o        (cal),
        .cmp_strobe_o (cstb),
        .busy_o       (busy),
        .done_o       (done),
        .trial_o      (trial),
        .codes_o      (codes)
    );

    // behavioural comparator: input at or above trial code
    always_comb begin
        for (int c = 0; c < NC; c++) begin
            cmp[c] = (vin[c] >= int'(trial[c*NB +: NB]));
        end
    end

    // cycle-level reference model
    always @(posedge clk) begin
        if (!rst_n) begin
            mph = 0; mcnt = 0; mbit = 0; mdone = 1'b0;
            for (int c = 0; c < NC; c++) begin mwork[c] = 0; mcode[c] = 0; end
        end else begin
            mdone = 1'b0;
            if (!enable) begin
                mph = 0; mcnt = 0;
            end else begin
                case (mph)
                    0: if (start) begin
                        mph = 1; mcnt = 0;
                        for (int c = 0; c < NC; c++) mwork[c] = 0;
                    end
                    1, 2: if (mcnt == SC-1) begin mph = mph + 1; mcnt = 0; end
                          else mcnt = mcnt + 1;
                    3: if (mcnt == CC-1) begin mph = 4; mcnt = 0; mbit = NB-1; end
                       else mcnt = mcnt + 1;
                    default: begin
                        for (int c = 0; c < NC; c++) begin
                            if (vin[c] >= (mwork[c] | (1 << mbit))) mwork[c] = mwork[c] | (1 << mbit);
                        end
                        if (mbit == 0) begin
                            mph = 0; mdone = 1'b1;
                            for (int c = 0; c < NC; c++) mcode[c] = mwork[c];
                        end else begin
                            mbit = mbit - 1;
                        end
                    end
                endcase
            end
        end
    end

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        cmp_n++;
        if (!ok) begin
            err_n++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        #(CLK_P/4);
        if (rst_n && !finished) begin
            logic [3:0] es;
            logic [NC*NB-1:0] et, ec;
            es = {enable && mph == 1, enable && mph == 2, enable && mph == 3, enable && mph == 4};
            for (int c = 0; c < NC; c++) begin
                et[c*NB +: NB] = (enable && mph == 4) ? NB'(mwork[c] | (1 << mbit)) : '0;
                ec[c*NB +: NB] = NB'(mcode[c]);
            end
            check({smp_rst, smp_sig, cal, cstb} == es, "R2/R7/R8 strobes", 64'({smp_rst, smp_sig, cal, cstb}), 64'(es));
            check(trial == et, "R3 trial codes", 64'(trial), 64'(et));
            check(busy == (mph != 0), "R10 busy", 64'(busy), 64'(mph != 0));
            check(done == mdone, "R5 done", 64'(done), 64'(mdone));
            check(codes == ec, "R4/R9 codes", 64'(codes), 64'(ec));
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !finished) begin
            finished = 1'b1;
            err_n++;
            cmp_n++;
            $display("FAIL watchdog expired actual=%0d expected<=20000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", cmp_n, err_n);
            $finish;
        end
    end

    task automatic set_vin(input int a0, a1, a2, a3, a4, a5, a6, a7);
        vin[0] = a0; vin[1] = a1; vin[2] = a2; vin[3] = a3;
        vin[4] = a4; vin[5] = a5; vin[6] = a6; vin[7] = a7;
    endtask

    // one conversion; p1/p2 are extra start pulses while busy; chain starts next in done cycle
    task automatic convert(input int p1, input int p2, input bit chain, input string tag);
        int n;
        if (!start) begin
            @(negedge clk);
            start = 1'b1;
        end
        n = 0;
        forever begin
            @(negedge clk);
            n++;
            start = (n == p1 || n == p2);
            #(CLK_P/4);
            if (done || n >= 4*LAT) break;
        end
        check(n == LAT, {tag, " R5 latency"}, 64'(n), 64'(LAT));
        for (int c = 0; c < NC; c++) begin
            int e;
            e = (vin[c] > MAXC) ? MAXC : vin[c];
            check(int'(codes[c*NB +: NB]) == e, {tag, " R4 R9 column code"}, 64'(codes[c*NB +: NB]), 64'(e));
        end
        start = chain;
    endtask

    initial begin
        logic [NC*NB-1:0] held;
        set_vin(0, 0, 0, 0, 0, 0, 0, 0);
        repeat (3) @(negedge clk);
        #(CLK_P/4);
        // R1: reset state
        check({smp_rst, smp_sig, cal, cstb, busy, done} == 6'b0, "R1 controls", 64'({smp_rst, smp_sig, cal, cstb, busy, done}), 64'(0));
        check(trial == '0 && codes == '0, "R1 codes", 64'(codes), 64'(0));
        @(negedge clk);
        rst_n = 1'b1;
        enable = 1'b1;

        set_vin(0, 63, 32, 31, 1, 62, 17, 200);
        convert(0, 0, 1'b0, "edge values");

        // R6: start pulses while busy
        set_vin(5, 40, 63, 0, 33, 12, 48, 7);
        convert(3, LAT-1, 1'b0, "R6 busy starts");

        // R11: start in done cycle
        set_vin(9, 18, 27, 36, 45, 54, 63, 2);
        convert(6, 0, 1'b1, "R11 chained first");
        set_vin(44, 21, 3, 60, 15, 29, 38, 50);
        convert(0, 0, 1'b0, "R11 chained second");

        // R7: enable dropped during calibration
        held = codes;
        set_vin(1, 2, 3, 4, 5, 6, 7, 8);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (2*SC + 1) @(negedge clk);
        enable = 1'b0;
        start = 1'b1;
        #(CLK_P/4);
        check({smp_rst, smp_sig, cal, cstb} == 4'b0, "R7 strobes off", 64'({smp_rst, smp_sig, cal, cstb}), 64'(0));
        check(trial == '0, "R7 trial off", 64'(trial), 64'(0));
        repeat (3) @(negedge clk);
        #(CLK_P/4);
        check(busy == 1'b0, "R7 start ignored", 64'(busy), 64'(0));
        @(negedge clk);
        start = 1'b0;
        enable = 1'b1;
        for (int k = 0; k < 2*LAT; k++) begin
            @(negedge clk);
            #(CLK_P/4);
            if (done) check(1'b0, "R7 no done after abort", 64'(done), 64'(0));
        end
        check(codes == held, "R7 codes kept", 64'(codes), 64'(held));

        // R9: distinct columns, recovery after abort
        set_vin(0, 9, 18, 27, 36, 45, 54, 63);
        convert(0, 0, 1'b0, "ramp");
        set_vin(32, 31, 33, 30, 34, 64, 16, 48);
        convert(0, 0, 1'b0, "midscale");

        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", cmp_n, err_n);
        $finish;
    end

endmodule